// File: doc/BRIEF.md
# DRAM Command Bus Stretcher

This block sits between a memory controller's command scheduler and the command/address pins of a DRAM channel. The scheduler offers one command, with its address, per issue slot through a valid/ready pair. The block registers each accepted command onto the pins and keeps it there for one, two or three DRAM clock cycles. A two-bit span field selects the count. While a command is being stretched, the ready signal stays low, so the scheduler cannot issue into the extra cycles.

The block also drives the output enable of the command/address bus. A keep-drive option bit selects what happens on idle slots. With the bit clear, an idle slot shows a NOP code and a zero address, and the bus floats whenever no rank has its clock enable asserted or the memory is in self-refresh. With the bit set, the bus is always driven and the last value on the pins stays there until a new command arrives.

PHY timing and chip-select generation belong to other blocks.

Top module: `cmd_stretch`

## Requirements
- R1: Synchronous active-low reset puts the NOP code (4'b0111 by default) and a zero address on the pins, clears the output enable and raises ready. This holds even in the middle of a stretched command.
- R2: A command accepted on a rising edge (valid and ready both high) appears on ca_cmd and ca_addr right after that edge.
- R3: With span code 2'b00, each command is held for one cycle and ready stays high, so commands can be accepted on consecutive cycles.
- R4: With span code 2'b10, each command is held for two cycles and ready is low for the one cycle after acceptance.
- R5: With span code 2'b11, each command is held for three cycles and ready is low for the two cycles after acceptance.
- R6: The reserved span code 2'b01 behaves exactly like 2'b00.
- R7: The span code is sampled only when a command is accepted. Changing it while a command is being stretched does not shorten or lengthen that command.
- R8: With keep-drive clear, an idle slot puts the NOP code and a zero address on the pins.
- R9: With keep-drive set, an idle slot leaves the previous command and address unchanged on the pins.
- R10: With keep-drive clear, ca_oe after an edge is high only when at least one bit of rank_cke was high and self_refresh was low before that edge. Otherwise ca_oe is low.
- R11: With keep-drive set, ca_oe is high after every edge, whatever the CKE and self-refresh state.
- R12: A valid command presented while ready is low is not taken, and the pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Scheduler offers a command |
| iss_cmd | input | CMD_W | Command code offered |
| iss_addr | input | ADDR_W | Address offered with the command |
| iss_ready | output | 1 | Block can accept a command on this edge |
| cfg_span | input | 2 | Span code: 00/01 one cycle, 10 two cycles, 11 three cycles |
| cfg_keep_drive | input | 1 | 1: always drive and hold the last command; 0: NOP on idle, float when ranks are down |
| rank_cke | input | NUM_RANKS | Clock-enable state of each rank |
| self_refresh | input | 1 | Memory is in self-refresh or a deeper state |
| ca_cmd | output | CMD_W | Command pins |
| ca_addr | output | ADDR_W | Address pins |
| ca_oe | output | 1 | Output enable of the command/address bus |

## Verification
Every pin output is registered, so ca_cmd, ca_addr and ca_oe respond to inputs exactly one rising edge after they are applied. iss_ready is decoded from the slot counter, so its value after that same edge already shows whether the stretch window is open. The bench drives inputs on the falling edge and samples every output on the next falling edge, one rising edge later. Each table row therefore states the pin, enable and ready values due after the edge it feeds. Stretch lengths are checked by walking successive rows through the two or three cycles of a held command.

// File: rtl/cmd_stretch_pkg.sv
`timescale 1ns/1ps
// Package: shared span-mode codes and counter sizing for the command stretcher.
// Assumes at most three cycles per command.
package cmd_stretch_pkg;
    localparam logic [1:0] SPAN_1N   = 2'b00;
    localparam logic [1:0] SPAN_RSVD = 2'b01;
    localparam logic [1:0] SPAN_2N   = 2'b10;
    localparam logic [1:0] SPAN_3N   = 2'b11;
    localparam int MAX_SPAN   = 3;
    localparam int SPAN_CNT_W = $clog2(MAX_SPAN + 1);
endpackage

// File: rtl/cs_span_decode.sv
`timescale 1ns/1ps
// Module: turns the two-bit span code into a cycle count (1..3).
// Assumes the reserved code is to be treated as one cycle.
module cs_span_decode
    import cmd_stretch_pkg::*;
(
    input  logic [1:0]            span_code,
    output logic [SPAN_CNT_W-1:0] span_len
);
    // Map each span code to the number of cycles a command is held.
    always_comb begin
        case (span_code)
            SPAN_2N: span_len = SPAN_CNT_W'(2);
            SPAN_3N: span_len = SPAN_CNT_W'(3);
            default: span_len = SPAN_CNT_W'(1);   // SPAN_1N and SPAN_RSVD
        endcase
    end
endmodule

// File: rtl/cs_slot_timer.sv
`timescale 1ns/1ps
// Module: counts the extra stretch cycles that remain after a command is
// accepted and gives ready when none remain. Assumes span_len is 1..MAX_SPAN
// and is sampled only on load, which keeps a running stretch unchanged.
module cs_slot_timer
    import cmd_stretch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SPAN_CNT_W-1:0] span_len,
    output logic                  ready
);
    logic [SPAN_CNT_W-1:0] remain_q;

    // Load the number of extra cycles on acceptance, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= span_len - SPAN_CNT_W'(1);
        else if (remain_q != '0)
            remain_q <= remain_q - SPAN_CNT_W'(1);
    end

    assign ready = (remain_q == '0);

    // R3: a one-cycle command leaves the next slot open.
    a_r3_single_slot_open: assert property (@(posedge clk) disable iff (!rst_n)
        load && span_len == SPAN_CNT_W'(1) |=> ready);
    // R4, R5: a longer command closes the next slot.
    a_r4_stretch_closes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        load && span_len > SPAN_CNT_W'(1) |=> !ready);
    // R5: a three-cycle command still blocks the second following slot.
    a_r5_three_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        load && span_len == SPAN_CNT_W'(3) |=> !ready ##1 !ready);
endmodule

// File: rtl/cs_bus_drive.sv
`timescale 1ns/1ps
// Module: registered command/address pins and their output enable.
// Assumes load is asserted only when the slot timer is not busy.
module cs_bus_drive #(
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 17,
    parameter int NUM_RANKS = 2,
    parameter logic [CMD_W-1:0] NOP_CMD = CMD_W'(7)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 busy,
    input  logic                 keep_drive,
    input  logic [CMD_W-1:0]     new_cmd,
    input  logic [ADDR_W-1:0]    new_addr,
    input  logic [NUM_RANKS-1:0] rank_cke,
    input  logic                 self_refresh,
    output logic [CMD_W-1:0]     pin_cmd,
    output logic [ADDR_W-1:0]    pin_addr,
    output logic                 pin_oe
);
    logic any_rank_up;
    logic oe_next;

    // The channel counts as active when any rank is up and no self-refresh is in force.
    always_comb begin
        any_rank_up = |rank_cke;
        oe_next     = keep_drive | (any_rank_up & ~self_refresh);
    end

    // Update the pins: new command, stretch hold, idle hold, or idle NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_cmd  <= NOP_CMD;
            pin_addr <= '0;
        end else if (load) begin
            pin_cmd  <= new_cmd;
            pin_addr <= new_addr;
        end else if (!busy && !keep_drive) begin
            pin_cmd  <= NOP_CMD;
            pin_addr <= '0;
        end
    end

    // Register the bus enable so it changes in step with the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_oe <= 1'b0;
        else
            pin_oe <= oe_next;
    end

    // R11: keep-drive forces the bus enabled.
    a_r11_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
        keep_drive |=> pin_oe);
    // R10: all ranks down or self-refresh floats the bus when keep-drive is clear.
    a_r10_float_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_drive && (rank_cke == '0 || self_refresh) |=> !pin_oe);
    // R8: an idle slot without keep-drive shows NOP.
    a_r8_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !busy && !keep_drive |=> pin_cmd == NOP_CMD && pin_addr == '0);
    // R9: an idle slot with keep-drive holds the pins.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load && keep_drive |=> $stable(pin_cmd) && $stable(pin_addr));
endmodule

// File: rtl/cmd_stretch.sv
`timescale 1ns/1ps
// Module: DRAM command bus stretcher top. Accepts one command per slot from
// the scheduler and holds it on the command/address pins for 1, 2 or 3
// cycles. Also drives the bus enable for the chosen idle behaviour.
// Assumes the scheduler honours iss_ready and that chip selects are made elsewhere.
module cmd_stretch #(
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 17,
    parameter int NUM_RANKS = 2,
    parameter logic [CMD_W-1:0] NOP_CMD = CMD_W'(7)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [CMD_W-1:0]     iss_cmd,
    input  logic [ADDR_W-1:0]    iss_addr,
    output logic                 iss_ready,
    input  logic [1:0]           cfg_span,
    input  logic                 cfg_keep_drive,
    input  logic [NUM_RANKS-1:0] rank_cke,
    input  logic                 self_refresh,
    output logic [CMD_W-1:0]     ca_cmd,
    output logic [ADDR_W-1:0]    ca_addr,
    output logic                 ca_oe
);
    import cmd_stretch_pkg::*;

    logic [SPAN_CNT_W-1:0] span_len;
    logic                  accept;

    // A command is taken only when offered in an open slot.
    assign accept = iss_valid & iss_ready;

    cs_span_decode u_decode (
        .span_code (cfg_span),
        .span_len  (span_len)
    );

    cs_slot_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .span_len (span_len),
        .ready    (iss_ready)
    );

    cs_bus_drive #(
        .CMD_W     (CMD_W),
        .ADDR_W    (ADDR_W),
        .NUM_RANKS (NUM_RANKS),
        .NOP_CMD   (NOP_CMD)
    ) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .busy         (~iss_ready),
        .keep_drive   (cfg_keep_drive),
        .new_cmd      (iss_cmd),
        .new_addr     (iss_addr),
        .rank_cke     (rank_cke),
        .self_refresh (self_refresh),
        .pin_cmd      (ca_cmd),
        .pin_addr     (ca_addr),
        .pin_oe       (ca_oe)
    );

    // R2: an accepted command reaches the pins after one edge.
    a_r2_cmd_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready |=> ca_cmd == $past(iss_cmd) && ca_addr == $past(iss_addr));
    // R12: during a stretch the pins hold, whatever is offered.
    a_r12_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |=> $stable(ca_cmd) && $stable(ca_addr));
endmodule

// File: tb/cmd_stretch_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven stimulus for cmd_stretch, then directed reset cases.
module cmd_stretch_tb_top;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 17;
    localparam int NR     = 2;
    localparam logic [CMD_W-1:0] NOP = 4'b0111;

    typedef struct packed {
        logic              v;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        span;
        logic              keep;
        logic [NR-1:0]     cke;
        logic              sr;
        logic [CMD_W-1:0]  e_cmd;
        logic [ADDR_W-1:0] e_addr;
        logic              e_oe;
        logic              e_rdy;
        logic [7:0]        req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'h3, 17'h11, 2'b00, 1'b0, 2'b11, 1'b0, 4'h3, 17'h11, 1'b1, 1'b1, 8'd3 },  // R3 R2
        '{1'b1, 4'h5, 17'h22, 2'b00, 1'b0, 2'b11, 1'b0, 4'h5, 17'h22, 1'b1, 1'b1, 8'd3 },  // R3 back-to-back
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b0, 2'b11, 1'b0, NOP,  17'h00, 1'b1, 1'b1, 8'd8 },  // R8
        '{1'b1, 4'h6, 17'h33, 2'b10, 1'b0, 2'b11, 1'b0, 4'h6, 17'h33, 1'b1, 1'b0, 8'd4 },  // R4 first cycle
        '{1'b0, 4'h0, 17'h00, 2'b10, 1'b0, 2'b11, 1'b0, 4'h6, 17'h33, 1'b1, 1'b1, 8'd4 },  // R4 second cycle
        '{1'b0, 4'h0, 17'h00, 2'b10, 1'b0, 2'b11, 1'b0, NOP,  17'h00, 1'b1, 1'b1, 8'd8 },  // R8
        '{1'b1, 4'h2, 17'h44, 2'b11, 1'b0, 2'b11, 1'b0, 4'h2, 17'h44, 1'b1, 1'b0, 8'd5 },  // R5 first cycle
        '{1'b1, 4'h9, 17'h55, 2'b00, 1'b0, 2'b11, 1'b0, 4'h2, 17'h44, 1'b1, 1'b0, 8'd12},  // R12 R7
        '{1'b1, 4'h9, 17'h55, 2'b00, 1'b0, 2'b11, 1'b0, 4'h2, 17'h44, 1'b1, 1'b1, 8'd7 },  // R7 R5 third
        '{1'b1, 4'h9, 17'h55, 2'b00, 1'b0, 2'b11, 1'b0, 4'h9, 17'h55, 1'b1, 1'b1, 8'd7 },  // R7 new code
        '{1'b1, 4'h4, 17'h66, 2'b01, 1'b0, 2'b11, 1'b0, 4'h4, 17'h66, 1'b1, 1'b1, 8'd6 },  // R6
        '{1'b1, 4'h1, 17'h77, 2'b01, 1'b0, 2'b11, 1'b0, 4'h1, 17'h77, 1'b1, 1'b1, 8'd6 },  // R6
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b1, 2'b11, 1'b0, 4'h1, 17'h77, 1'b1, 1'b1, 8'd9 },  // R9
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b1, 2'b00, 1'b0, 4'h1, 17'h77, 1'b1, 1'b1, 8'd11},  // R11
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b0, 2'b00, 1'b0, NOP,  17'h00, 1'b0, 1'b1, 8'd10},  // R10 ranks down
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b0, 2'b01, 1'b0, NOP,  17'h00, 1'b1, 1'b1, 8'd10},  // R10 one rank up
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b0, 2'b11, 1'b1, NOP,  17'h00, 1'b0, 1'b1, 8'd10},  // R10 self-refresh
        '{1'b0, 4'h0, 17'h00, 2'b00, 1'b1, 2'b11, 1'b1, NOP,  17'h00, 1'b1, 1'b1, 8'd11}   // R11 self-refresh
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [CMD_W-1:0]  iss_cmd = '0;
    logic [ADDR_W-1:0] iss_addr = '0;
    logic              iss_ready;
    logic [1:0]        cfg_span = 2'b10;
    logic              cfg_keep_drive = 1'b0;
    logic [NR-1:0]     rank_cke = '0;
    logic              self_refresh = 1'b0;
    logic [CMD_W-1:0]  ca_cmd;
    logic [ADDR_W-1:0] ca_addr;
    logic              ca_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cmd_stretch #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .NUM_RANKS(NR), .NOP_CMD(NOP)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_addr(iss_addr), .iss_ready(iss_ready), .cfg_span(cfg_span),
        .cfg_keep_drive(cfg_keep_drive), .rank_cke(rank_cke),
        .self_refresh(self_refresh), .ca_cmd(ca_cmd), .ca_addr(ca_addr), .ca_oe(ca_oe)
    );

    // Compare all outputs against expected values and log any mismatch.
    task automatic check_all(input string tag, input logic [CMD_W-1:0] e_cmd,
                             input logic [ADDR_W-1:0] e_addr, input logic e_oe,
                             input logic e_rdy);
        n_checks++;
        if (ca_cmd !== e_cmd || ca_addr !== e_addr || ca_oe !== e_oe || iss_ready !== e_rdy) begin
            n_fails++;
            $display("FAIL %s: cmd=%h addr=%h oe=%b rdy=%b expected cmd=%h addr=%h oe=%b rdy=%b",
                     tag, ca_cmd, ca_addr, ca_oe, iss_ready, e_cmd, e_addr, e_oe, e_rdy);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset state", NOP, '0, 1'b0, 1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            iss_valid      = VECS[i].v;
            iss_cmd        = VECS[i].cmd;
            iss_addr       = VECS[i].addr;
            cfg_span       = VECS[i].span;
            cfg_keep_drive = VECS[i].keep;
            rank_cke       = VECS[i].cke;
            self_refresh   = VECS[i].sr;
            @(negedge clk);
            check_all($sformatf("R%0d row %0d", VECS[i].req, i),
                      VECS[i].e_cmd, VECS[i].e_addr, VECS[i].e_oe, VECS[i].e_rdy);
        end
        // R1: reset in the middle of a three-cycle command.
        iss_valid = 1'b1; iss_cmd = 4'hA; iss_addr = 17'h99; cfg_span = 2'b11;
        cfg_keep_drive = 1'b0; rank_cke = 2'b11; self_refresh = 1'b0;
        @(negedge clk);
        check_all("R5 start before reset", 4'hA, 17'h99, 1'b1, 1'b0);
        rst_n = 1'b0; iss_valid = 1'b0;
        @(negedge clk);
        check_all("R1 reset mid-stretch", NOP, '0, 1'b0, 1'b1);
        // R4: first command after reset in two-cycle mode.
        rst_n = 1'b1; iss_valid = 1'b1; iss_cmd = 4'hB; iss_addr = 17'h1ABCD; cfg_span = 2'b10;
        @(negedge clk);
        check_all("R4 after reset", 4'hB, 17'h1ABCD, 1'b1, 1'b0);
        iss_valid = 1'b0;
        @(negedge clk);
        check_all("R4 second cycle after reset", 4'hB, 17'h1ABCD, 1'b1, 1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule